// File: doc/BRIEF.md
# Multi-channel event timer

This block is a register-mapped event timer. A 64-bit main counter advances by one on every clock while the run bit is set. A small set of comparator channels watches that counter. Software reaches all state through one 32-bit read/write port: it sets up the counter, programs comparators, and reads or clears the per-channel event flags.

A channel fires only when the counter equals its comparator exactly. A one-shot channel fires once. A periodic channel adds its stored period to the comparator after each match. Periodic set-up takes two writes to one comparator offset: the first write, made while the set-value bit is high, loads the first match point and clears that bit; the second loads the period. Each channel makes an interrupt that is either a one-clock pulse or a level held until software clears the flag. With legacy routing on, channels 0 and 1 drive two fixed lines. Otherwise every channel drives the route line that its config word selects.

Top module: `evt_timer`

## Requirements
- R1: Offset 0x000 reads bits [4:0] = channel count minus one and bit 8 = 1 (legacy routing supported), all other bits zero. Offset 0x004 reads the tick period in femtoseconds (parameter PERIOD_FS). Any unmapped offset reads zero.
- R2: Global config at 0x010: bit 0 is run and bit 1 is legacy routing. While run is 1 the counter grows by exactly one per clock. While run is 0 it holds its value.
- R3: The counter reads as the low word at 0x030 and the high word at 0x034. Each half can be written while run is 0. Writes to either half are ignored while run is 1.
- R4: Channel n lives at 0x100 + 32*n: config at +0x00, comparator low at +0x08, comparator high at +0x0C. An enabled channel (config bit 1) sets status bit n at 0x020 only on a clock in which the running counter equals its comparator exactly. A comparator value that the counter has already passed does not fire.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R6: With config bit 0 = 1 (level), the channel interrupt stays high while its status bit is set. With bit 0 = 0 (edge), the interrupt is a single one-clock pulse, visible in the same cycle the status bit appears.
- R7: With config bit 2 (periodic) and bit 4 (set-value) both high, a comparator-low write loads the match value and clears bit 4. Later comparator writes load the period. After each match the comparator advances by the period.
- R8: With config bit 5 (32-bit mode) set, the channel compares only the low 32 counter bits, and periodic advance wraps modulo 2^32.
- R9: With legacy routing on, channel 0 drives irq_tick, channel 1 drives irq_rtc, and neither drives irq_route. Every other channel, and every channel when legacy routing is off, drives irq_route[config bits 9:8]. When legacy routing is off, irq_tick and irq_rtc stay low.
- R10: Read-only fields ignore writes. This covers the ID and period words, config bit 3 (periodic capable, reads 1) and config bit 7 (message delivery capable, reads 0).
- R11: A comparator write takes effect for matching within two clocks of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter ticks on it |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_tick | output | 1 | Legacy system-tick line (channel 0) |
| irq_rtc | output | 1 | Legacy real-time-clock line (channel 1) |
| irq_route | output | NROUTE | Routed channel interrupt lines |

## Verification
On every cycle, the assertions check the counter step and hold rules, that a status flag rises only on a real match, that write-one-to-clear takes effect, that edge pulses follow a match, that set-value clears on its first comparator write, and that the legacy lines are silent when routing is off. Only the bench scenarios can show exact-equality timing measured at the ports: match cycles after a late comparator write, the periodic sequence over several periods in both 64-bit and 32-bit mode, and the route mapping in each legacy setting. The same applies to a passed comparator that must stay silent.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int          NCH       = 3,
  parameter logic [31:0] PERIOD_FS = 32'd8000000,
  parameter int          NROUTE    = 4,
  parameter int          AW        = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_tick,
  output logic              irq_rtc,
  output logic [NROUTE-1:0] irq_route
);
  localparam int RW = (NROUTE > 1) ? $clog2(NROUTE) : 1;

  logic        run, legacy;
  logic [63:0] cnt;
  logic [NCH-1:0] sts, pulse, fire, ch_irq;
  logic [NCH-1:0] c_lvl, c_en, c_per, c_set, c_f32, c_msg;
  logic [NCH-1:0] wr_cf, wr_cl, wr_ch;
  logic [RW-1:0] c_rt [NCH];
  logic [63:0]   cmp  [NCH];
  logic [63:0]   per  [NCH];

  wire       chsel  = bus_addr[AW-1:8] == (AW-8)'(1);
  wire [2:0] chi    = bus_addr[7:5];
  wire [4:0] choff  = bus_addr[4:0];
  wire       wr_gc  = bus_wr && bus_addr == AW'(12'h010);
  wire       wr_sts = bus_wr && bus_addr == AW'(12'h020);
  wire       wr_lo  = bus_wr && bus_addr == AW'(12'h030);
  wire       wr_hi  = bus_wr && bus_addr == AW'(12'h034);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      wr_cf[i]  = bus_wr && chsel && chi == 3'(i) && choff == 5'h00;
      wr_cl[i]  = bus_wr && chsel && chi == 3'(i) && choff == 5'h08;
      wr_ch[i]  = bus_wr && chsel && chi == 3'(i) && choff == 5'h0C;
      fire[i]   = run && c_en[i] &&
                  (c_f32[i] ? (cnt[31:0] == cmp[i][31:0]) : (cnt == cmp[i]));
      ch_irq[i] = c_lvl[i] ? sts[i] : pulse[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; legacy <= 1'b0; cnt <= '0;
      sts <= '0; pulse <= '0;
      c_lvl <= '0; c_en <= '0; c_per <= '0; c_set <= '0; c_f32 <= '0; c_msg <= '0;
      for (int i = 0; i < NCH; i++) begin
        cmp[i] <= '0; per[i] <= '0; c_rt[i] <= '0;
      end
    end else begin
      if (wr_gc) begin
        run    <= bus_wdata[0];
        legacy <= bus_wdata[1];
      end
      if (run)        cnt <= cnt + 64'd1;
      else if (wr_lo) cnt[31:0]  <= bus_wdata;
      else if (wr_hi) cnt[63:32] <= bus_wdata;
      pulse <= fire;
      for (int i = 0; i < NCH; i++) begin
        if (fire[i])                       sts[i] <= 1'b1;
        else if (wr_sts && bus_wdata[i])   sts[i] <= 1'b0;
        if (wr_cf[i]) begin
          c_lvl[i] <= bus_wdata[0];
          c_en[i]  <= bus_wdata[1];
          c_per[i] <= bus_wdata[2];
          c_set[i] <= bus_wdata[4];
          c_f32[i] <= bus_wdata[5];
          c_msg[i] <= bus_wdata[6];
          c_rt[i]  <= bus_wdata[8 +: RW];
        end
        if (wr_cl[i]) begin
          if (c_per[i] && !c_set[i]) per[i][31:0] <= bus_wdata;
          else begin
            cmp[i][31:0] <= bus_wdata;
            c_set[i]     <= 1'b0;
          end
        end else if (wr_ch[i]) begin
          if (c_per[i] && !c_set[i]) per[i][63:32] <= bus_wdata;
          else                       cmp[i][63:32] <= bus_wdata;
        end else if (fire[i] && c_per[i]) begin
          if (c_f32[i]) cmp[i][31:0] <= cmp[i][31:0] + per[i][31:0];
          else          cmp[i]       <= cmp[i] + per[i];
        end
      end
    end
  end

  always_comb begin
    irq_tick  = legacy && ch_irq[0];
    irq_rtc   = legacy && ch_irq[1];
    irq_route = '0;
    for (int i = 0; i < NCH; i++)
      if (!(legacy && i < 2))
        irq_route[c_rt[i]] = irq_route[c_rt[i]] | ch_irq[i];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(12'h000): bus_rdata = {23'd0, 1'b1, 3'd0, 5'(NCH-1)};
      AW'(12'h004): bus_rdata = PERIOD_FS;
      AW'(12'h010): bus_rdata = {30'd0, legacy, run};
      AW'(12'h020): bus_rdata = 32'(sts);
      AW'(12'h030): bus_rdata = cnt[31:0];
      AW'(12'h034): bus_rdata = cnt[63:32];
      default: ;
    endcase
    for (int i = 0; i < NCH; i++)
      if (chsel && chi == 3'(i))
        case (choff)
          5'h00: bus_rdata = {{(23-RW){1'b0}}, c_rt[i], 1'b0, c_msg[i], c_f32[i],
                              c_set[i], 1'b1, c_per[i], c_en[i], c_lvl[i]};
          5'h08: bus_rdata = cmp[i][31:0];
          5'h0C: bus_rdata = cmp[i][63:32];
          default: ;
        endcase
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + 64'd1);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> $stable(cnt));
  // R9
  legacy_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy |-> (!irq_tick && !irq_rtc));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R4
    sts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[g]) |-> $past(fire[g]));
    // R5
    sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && bus_wdata[g] && !fire[g]) |=> !sts[g]);
    // R6
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[g] |-> $past(fire[g]));
    // R7
    setval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cl[g] && c_per[g] && c_set[g]) |=> !c_set[g]);
  end
endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  localparam int NCH = 3;
  localparam logic [31:0] PFS = 32'd8000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_tick, irq_rtc;
  logic [3:0]  irq_route;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_timer #(.NCH(NCH), .PERIOD_FS(PFS), .NROUTE(4), .AW(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_tick(irq_tick),
    .irq_rtc(irq_rtc), .irq_route(irq_route));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [11:0] chad(input int ch, input int off);
    return 12'(256 + 32 * ch + off);
  endfunction

  task automatic set_cnt(input logic [63:0] v);
    wr(12'h010, 32'h0);
    wr(12'h030, v[31:0]);
    wr(12'h034, v[63:32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c, c2;
    int k;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state and identity
    rd(12'h000, d); chk("R1 id", d, 32'h102);
    rd(12'h004, d); chk("R1 period", d, PFS);
    rd(12'h0FC, d); chk("R1 unmapped", d, 0);
    rd(12'h010, d); chk("R2 config reset", d, 0);
    rd(12'h020, d); chk("R5 status reset", d, 0);
    rd(12'h030, d); chk("R3 counter reset", d, 0);
    rd(chad(0, 0), d); chk("R10 chan cfg reset", d, 32'h8);

    // R10 read-only fields
    wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, d); chk("R10 id write", d, 32'h102);
    wr(12'h004, 32'h0); rd(12'h004, d); chk("R10 period write", d, PFS);
    wr(chad(0, 0), 32'h80); rd(chad(0, 0), d); chk("R10 cap bits", d, 32'h8);
    wr(chad(0, 0), 32'h0);

    // R3 counter halves while stopped
    set_cnt(64'h5_0000_0100);
    rd(12'h030, d); chk("R3 low write", d, 32'h100);
    rd(12'h034, d); chk("R3 high write", d, 32'h5);
    set_cnt(64'd100);
    // R2 counting and holding
    wr(12'h010, 32'h1);
    rd(12'h030, c); tick(25); rd(12'h030, c2);
    chk("R2 count step", c2 - c, 25);
    wr(12'h010, 32'h0);
    rd(12'h030, c); tick(10); rd(12'h030, c2);
    chk("R2 hold", c2, c);
    // R3 writes ignored while running
    wr(12'h010, 32'h1);
    rd(12'h030, c); wr(12'h030, 32'h0); rd(12'h030, d);
    chk("R3 low ignored running", d, c + 1);
    wr(12'h034, 32'h7); rd(12'h034, d);
    chk("R3 high ignored running", d, 0);

    // R4 / R6 edge exact match
    set_cnt(64'd0);
    wr(chad(0, 0), 32'h2);
    wr(chad(0, 8), 32'd20);
    wr(chad(0, 12), 32'd0);
    wr(12'h010, 32'h1);
    seen = 1'b0;
    for (int t = 0; t < 60 && !seen; t++) begin
      tick(1);
      rd(12'h020, d);
      if (d[0]) begin
        seen = 1'b1;
        rd(12'h030, c);
        chk("R4 match cycle", c, 21);
        chk("R6 edge pulse high", irq_route[0], 1);
        tick(1);
        chk("R6 edge pulse single", irq_route[0], 0);
      end
    end
    chk("R4 fired", seen, 1);
    // R4 passed value never fires
    wr(chad(1, 8), 32'd5);
    wr(chad(1, 12), 32'd0);
    wr(chad(1, 0), 32'h2);
    tick(40);
    rd(12'h020, d); chk("R4 passed compare silent", d[1], 0);
    // R5 write-one-to-clear
    wr(12'h020, 32'h0); rd(12'h020, d); chk("R5 write zero keeps", d[0], 1);
    wr(12'h020, 32'h1); rd(12'h020, d); chk("R5 write one clears", d[0], 0);
    // R11 late comparator write
    rd(12'h030, c);
    wr(chad(1, 8), c + 2);
    tick(2);
    rd(12'h020, d); chk("R11 compare takes effect", d[1], 1);
    rd(12'h030, d); chk("R11 match counter", d, c + 3);
    wr(12'h020, 32'h2);
    // R6 level
    wr(chad(1, 0), 32'h0);
    wr(chad(0, 0), 32'h3);
    rd(12'h030, c);
    wr(chad(0, 8), c + 10);
    tick(15);
    chk("R6 level high", irq_route[0], 1);
    tick(20);
    chk("R6 level held", irq_route[0], 1);
    wr(12'h020, 32'h1);
    chk("R6 level released", irq_route[0], 0);

    // R8 32-bit compare
    set_cnt(64'h1_0000_0000);
    wr(12'h020, 32'h7);
    wr(chad(0, 0), 32'h22); wr(chad(0, 8), 32'd15); wr(chad(0, 12), 32'd0);
    wr(chad(1, 0), 32'h02); wr(chad(1, 8), 32'd15); wr(chad(1, 12), 32'd0);
    wr(12'h010, 32'h1);
    tick(30);
    rd(12'h020, d); chk("R8 only 32-bit channel fires", d, 32'h1);

    // R7 periodic sweep over periods and width modes
    wr(chad(0, 0), 32'h0); wr(chad(1, 0), 32'h0);
    for (int f = 0; f < 2; f++) begin
      for (int pi = 0; pi < 4; pi++) begin
        int p;
        p = (pi == 0) ? 3 : (pi == 1) ? 4 : (pi == 2) ? 5 : 7;
        set_cnt(f ? 64'h5_0000_0000 : 64'd0);
        wr(12'h020, 32'h7);
        wr(chad(2, 0), 32'h116 | (f ? 32'h20 : 32'h0));
        rd(chad(2, 0), d); chk("R7 setval stored", d[4], 1);
        wr(chad(2, 8), 32'd10);
        rd(chad(2, 0), d); chk("R7 setval cleared", d[4], 0);
        wr(chad(2, 8), 32'(p));
        rd(chad(2, 8), d); chk("R7 first match kept", d, 10);
        wr(12'h010, 32'h1);
        k = 0;
        for (int t = 0; t < 80 && k < 4; t++) begin
          tick(1);
          if (irq_route[1]) begin
            rd(12'h030, c);
            chk(f ? "R8 periodic 32-bit match" : "R7 periodic match", c, 32'(10 + p * k + 1));
            k++;
          end
        end
        chk("R7 match count", k, 4);
      end
    end
    wr(12'h010, 32'h0);
    wr(chad(2, 0), 32'h0);

    // R9 legacy routing
    set_cnt(64'd0);
    wr(12'h020, 32'h7);
    wr(chad(0, 0), 32'h003); wr(chad(0, 8), 32'd5); wr(chad(0, 12), 32'd0);
    wr(chad(1, 0), 32'h303); wr(chad(1, 8), 32'd6);
    wr(chad(2, 0), 32'h103); wr(chad(2, 8), 32'd7); wr(chad(2, 12), 32'd0);
    wr(12'h010, 32'h3);
    tick(20);
    chk("R9 legacy tick", irq_tick, 1);
    chk("R9 legacy rtc", irq_rtc, 1);
    chk("R9 legacy route", irq_route, 4'b0010);
    wr(12'h010, 32'h1);
    chk("R9 plain tick low", irq_tick, 0);
    chk("R9 plain rtc low", irq_rtc, 0);
    chk("R9 plain route", irq_route, 4'b1011);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule